// File: doc/BRIEF.md
# Interrupt Source Pending Aggregator

The block follows a fixed set of interrupt sources and decides when the CPU must be interrupted. Each source has a level line and an enable counter. Several independent enabling contributors may gate a single source, such as mask bits, priority fields or group switches. Each contributor sends an increment pulse when it turns on and a decrement pulse when it turns off. A source counts as enabled only when its counter has reached a constant requirement fixed at elaboration. A source is pending when its line is asserted and it is enabled.

Rise and fall events of the per-source pending flags feed a running tally of pending sources, and the CPU request line is driven from that tally. When the CPU asks for a vector, a combinational lookup returns the stored vector of the lowest-indexed pending source. The lookup reports nothing valid when no source is pending or when the CPU mask is at its blocking value 4'hF.

Top module: `irq_pend_agg`

## Requirements
- R1: While reset is held, and right after it, `irq_o`, `vec_valid_o` and `vec_o` are 0, every enable counter is 0 and no source is asserted.
- R2: Source i becomes pending after the clock edge at which it is asserted and its enable counter equals its requirement. Either condition alone leaves it not pending.
- R3: The asserted flag of a source takes the value of its level line at each clock edge. Holding the line at the same level changes nothing at the outputs.
- R4: The enable counter stops at its requirement on extra increments and at 0 on extra decrements. After N surplus increments, one decrement still disables the source.
- R5: An increment and a decrement to the same source in the same cycle leave its counter unchanged.
- R6: `irq_o` is 1 exactly when the tally of pending sources is non-zero. The tally follows every rise and fall of the pending flags, including several sources changing on the same edge. `irq_o` changes on the same edge as the pending flags.
- R7: When `vec_valid_o` is 1, `vec_o` is the vector of the lowest-indexed pending source. The vector of source i is VEC_BASE + i*VEC_STEP, which is 12'h400 + i*12'h020 by default.
- R8: When `imask_i` equals 4'hF, `vec_valid_o` is 0 and `vec_o` is 0 whatever is pending. Any other mask value does not block the lookup. `irq_o` does not depend on the mask.
- R9: When no source is pending, `vec_valid_o` is 0 and `vec_o` is 0.
- R10: The enable requirement of source i is 1 + (i mod REQ_SPAN), which gives 1, 2, 3, 1, 2, 3, 1, 2 for the default of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | NUM_SRC | Per-source interrupt level lines |
| en_inc_i | input | NUM_SRC | Per-source enable increment pulses |
| en_dec_i | input | NUM_SRC | Per-source enable decrement pulses |
| imask_i | input | 4 | CPU interrupt mask; 4'hF blocks the vector lookup |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | VEC_W | Vector of the selected pending source |
| vec_valid_o | output | 1 | `vec_o` holds a valid vector |

## Verification
The first pattern raises single sources with lines and enables in different orders. This shows that pending needs both conditions and that requirements of 1 and 2 differ. Surplus increments followed by one decrement, and increment and decrement pulses landing in the same cycle, tell a saturating counter apart from one that wraps or one that gives one pulse priority. A pattern that makes every source pending at once and then drops all but the highest, or all of them, shows whether the tally sums simultaneous events or only counts one per edge. Sweeping the mask between 4'hF and other values while sources are pending separates blocking of the vector from blocking of the request.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam logic [3:0] MASK_BLOCK_ALL = 4'hF;

  // enable requirement of a source index
  function automatic int unsigned req_of(input int unsigned idx, input int unsigned span);
    return 1 + (idx % span);
  endfunction

  // vector value of a source index
  function automatic int unsigned vec_of(input int unsigned idx, input int unsigned base,
                                         input int unsigned step);
    return base + idx * step;
  endfunction

  // saturating enable count update
  function automatic int unsigned sat_step(input int unsigned cnt, input int unsigned req,
                                           input logic inc, input logic dec);
    if (inc && !dec) return (cnt >= req) ? req : cnt + 1;
    if (dec && !inc) return (cnt == 0) ? 0 : cnt - 1;
    return cnt;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_agg_pkg::*;
#(
  parameter int unsigned REQ   = 1,
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o,
  output logic rise_o,
  output logic fall_o
);

  localparam logic [CNT_W-1:0] REQ_V = CNT_W'(REQ);

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             asrt_q;
  logic             pend_q, pend_next;

  always_comb begin
    cnt_next  = CNT_W'(sat_step(32'(cnt_q), REQ, inc_i, dec_i));
    pend_next = level_i && (cnt_next == REQ_V);
  end

  assign rise_o = pend_next && !pend_q;
  assign fall_o = !pend_next && pend_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      asrt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      asrt_q <= level_i;
      pend_q <= pend_next;
    end
  end

  // R2
  pend_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (asrt_q && cnt_q == REQ_V));

  // R4
  cnt_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == REQ_V && inc_i && !dec_i) |=> (cnt_q == REQ_V));

  // R4
  cnt_floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec_i && !inc_i) |=> (cnt_q == '0));

  // R5
  cnt_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/irq_pend_tally.sv
module irq_pend_tally #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  output logic               irq_o
);

  localparam int unsigned TW = $clog2(NUM_SRC + 1);

  logic [TW-1:0] tally_q, tally_next;
  logic          irq_q;
  int unsigned   ups, downs;

  always_comb begin
    ups   = 0;
    downs = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ups   = ups + 32'(rise_i[i]);
      downs = downs + 32'(fall_i[i]);
    end
    tally_next = TW'(32'(tally_q) + ups - downs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tally_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      tally_q <= tally_next;
      irq_q   <= (tally_next != '0);
    end
  end

  assign irq_o = irq_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tally_q) <= NUM_SRC);

  // R6
  irq_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (tally_q != '0));

endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned VEC_W    = 12,
  parameter int unsigned VEC_BASE = 32'h400,
  parameter int unsigned VEC_STEP = 32'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [3:0]         imask_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               valid_o
);

  logic [VEC_W-1:0] vec_tab [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_tab
    assign vec_tab[g] = VEC_W'(vec_of(g, VEC_BASE, VEC_STEP));
  end

  logic blocked;
  assign blocked = (imask_i == MASK_BLOCK_ALL);

  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && !blocked) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = vec_tab[i];
      end
    end
    valid_o = |grant_o;
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R7
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((((grant_o - 1'b1) & pend_i) == '0) && ((grant_o & pend_i) != '0)));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!valid_o && vec_o == '0));

  // R9
  idle_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> (!valid_o && vec_o == '0));

endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned VEC_W    = 12,
  parameter int unsigned REQ_SPAN = 3,
  parameter int unsigned VEC_BASE = 32'h400,
  parameter int unsigned VEC_STEP = 32'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] en_inc_i,
  input  logic [NUM_SRC-1:0] en_dec_i,
  input  logic [3:0]         imask_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);

  localparam int unsigned CNT_W = $clog2(REQ_SPAN + 1);

  logic [NUM_SRC-1:0] pend_w, rise_w, fall_w, grant_w;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    localparam int unsigned REQ_G = req_of(g, REQ_SPAN);  // R10
    irq_src_slot #(.REQ(REQ_G), .CNT_W(CNT_W)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(level_i[g]),
      .inc_i  (en_inc_i[g]),
      .dec_i  (en_dec_i[g]),
      .pend_o (pend_w[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );
  end

  irq_pend_tally #(.NUM_SRC(NUM_SRC)) tally_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rise_i(rise_w),
    .fall_i(fall_w),
    .irq_o (irq_o)
  );

  irq_vec_pick #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) pick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_w),
    .imask_i(imask_i),
    .grant_o(grant_w),
    .vec_o  (vec_o),
    .valid_o(vec_valid_o)
  );

  // R6
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_w != '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && !vec_valid_o));

endmodule

// File: tb/irq_pend_agg_tb_top.sv
module irq_pend_agg_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] level_i = '0, en_inc_i = '0, en_dec_i = '0;
  logic [3:0]   imask_i = 4'h0;
  logic         irq_o, vec_valid_o;
  logic [11:0]  vec_o;

  always #10 clk = ~clk;  // 50 MHz

  irq_pend_agg dut_i (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .en_inc_i(en_inc_i),
    .en_dec_i(en_dec_i), .imask_i(imask_i), .irq_o(irq_o), .vec_o(vec_o),
    .vec_valid_o(vec_valid_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  int cnt_m[N];
  bit pend_m[N];

  function automatic int req_m(int i);
    return (i % 3) + 1;
  endfunction

  // driver: drive one cycle of stimulus and predict the outputs after the edge
  task automatic step(input logic [N-1:0] lv, input logic [N-1:0] inc,
                      input logic [N-1:0] dec, input logic [3:0] msk, input string tag);
    logic [13:0] e;
    bit any;
    @(negedge clk);
    level_i = lv; en_inc_i = inc; en_dec_i = dec; imask_i = msk;
    any = 0;
    e = '0;
    for (int i = 0; i < N; i++) begin
      if (inc[i] && !dec[i] && cnt_m[i] < req_m(i)) cnt_m[i]++;
      else if (dec[i] && !inc[i] && cnt_m[i] > 0) cnt_m[i]--;
      pend_m[i] = lv[i] && (cnt_m[i] == req_m(i));
      any |= pend_m[i];
    end
    e[13] = any;
    if (any && msk != 4'hF) begin
      e[12] = 1'b1;
      for (int i = N - 1; i >= 0; i--)
        if (pend_m[i]) e[11:0] = 12'h400 + 12'(i) * 12'h020;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [13:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {irq_o, vec_valid_o, vec_o};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: irq/valid/vec actual=%b/%b/%h expected=%b/%b/%h",
                 t, a[13], a[12], a[11:0], e[13], e[12], e[11:0]);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin cnt_m[i] = 0; pend_m[i] = 0; end
    repeat (3) @(posedge clk);
    #5;
    total++;  // R1 during reset
    if ({irq_o, vec_valid_o, vec_o} !== 14'h0) begin
      bad++;
      $display("FAIL R1: actual=%b/%b/%h expected=0/0/000", irq_o, vec_valid_o, vec_o);
    end
    @(negedge clk); rst_n = 1'b1;
    step(8'h00, 8'h00, 8'h00, 4'h0, "R1");
    step(8'h01, 8'h00, 8'h00, 4'h0, "R2 level only");
    step(8'h01, 8'h01, 8'h00, 4'h0, "R2 level and enable");
    step(8'h01, 8'h00, 8'h00, 4'h0, "R3 held level");
    step(8'h03, 8'h02, 8'h00, 4'h0, "R10 src1 needs two");
    step(8'h03, 8'h02, 8'h00, 4'h0, "R7 lowest wins");
    step(8'h03, 8'h00, 8'h00, 4'hF, "R8 mask blocks");
    step(8'h03, 8'h00, 8'h00, 4'hE, "R8 other mask");
    step(8'h02, 8'h00, 8'h00, 4'h0, "R3 drop src0");
    step(8'h02, 8'h01, 8'h00, 4'h0, "R4 surplus inc");
    step(8'h02, 8'h01, 8'h00, 4'h0, "R4 surplus inc");
    step(8'h02, 8'h01, 8'h00, 4'h0, "R4 surplus inc");
    step(8'h02, 8'h00, 8'h01, 4'h0, "R4 one dec");
    step(8'h03, 8'h00, 8'h00, 4'h0, "R4 src0 disabled");
    step(8'h03, 8'h00, 8'h01, 4'h0, "R4 dec at zero");
    step(8'h03, 8'h01, 8'h00, 4'h0, "R4 floor held");
    step(8'h03, 8'h02, 8'h02, 4'h0, "R5 inc and dec");
    step(8'h02, 8'h00, 8'h02, 4'h0, "R6 src1 falls");
    step(8'h00, 8'h00, 8'h00, 4'h0, "R9 none pending");
    step(8'h00, 8'hFF, 8'h00, 4'h0, "R10 fill");
    step(8'h00, 8'hFF, 8'h00, 4'h0, "R10 fill");
    step(8'h00, 8'hFF, 8'h00, 4'h0, "R10 fill");
    step(8'hFF, 8'h00, 8'h00, 4'h0, "R6 all rise");
    step(8'h80, 8'h00, 8'h00, 4'h0, "R6 seven fall");
    step(8'h80, 8'h00, 8'h00, 4'hF, "R8 irq stays");
    step(8'h00, 8'h00, 8'h00, 4'h0, "R6 last falls");
    step(8'h24, 8'h00, 8'h00, 4'h0, "R7 src2 and src5");
    step(8'h20, 8'h00, 8'h00, 4'h0, "R7 src5 only");
    step(8'h20, 8'h00, 8'h20, 4'h0, "R2 src5 disabled");
    step(8'h00, 8'h00, 8'h00, 4'h0, "R9 idle");
    while (exp_q.size() > 0) @(posedge clk);
    #6;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule